// File: doc/BRIEF.md
# Attribute Request Register Bridge

This block sits between a byte-wide host register bus and a downstream configuration engine. Software builds a request in four staging bytes: a 16-bit attribute value and a 16-bit attribute code, each split into a low and a high byte. It then writes the issue register to launch the request. The code and value are copied into a request register at that moment, so software may prepare the next request while the current one is in flight. A typical request is the pattern-checker control attribute, code 0x0002, with a value that selects the pattern.

Progress is shown in two places. A busy bit is set while the request is outstanding. A sticky done flag is set when the request completes, and software clears it by writing 1 to its bit. Host reads are combinational and return in the same cycle, and the host bus has no wait states. The downstream port uses valid/ready. Once `dn_valid` rises, it stays high and `dn_code`/`dn_value` stay frozen until the engine raises `dn_ready`. The engine may hold `dn_ready` low for any number of cycles (back-pressure). A transfer occurs on the rising clock edge where both signals are high. `dn_valid` falls in the cycle after that edge, and no new transfer begins until software issues again.

Top module: `attr_req_bridge`

## Requirements
- R1: Address 0x84 holds the low byte and 0x85 the high byte of the staged attribute value. Both reset to 0 and read back what was written.
- R2: Address 0x86 holds the low byte and 0x87 the high byte of the staged attribute code. Both reset to 0 and read back what was written.
- R3: While idle, a write to 0x90 with bit 7 = 1 starts a request. In the next cycle `dn_valid` is 1 and `dn_code`/`dn_value` equal the staged code and value. A write to 0x90 with bit 7 = 0 does nothing. 0x90 reads as 0.
- R4: Bit 0 of 0x8B reads 1 from the cycle after a request is issued until the transfer edge, and 0 from the cycle after that edge. Bits 7:1 of 0x8B read 0.
- R5: Bit 7 of 0x8A (done) resets to 0 and is set in the cycle after the transfer edge. It stays set until a write to 0x8A with bit 7 = 1 clears it. Writing 0 to bit 7 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins. Bits 6:0 read 0.
- R6: `dn_code` and `dn_value` stay stable while a request is outstanding. Writes to 0x84–0x87 during that time do not change them.
- R7: A write to 0x90 while busy is ignored. It neither starts a second request nor changes the outstanding one.
- R8: Every address other than 0x84–0x87, 0x8A and 0x8B reads 0. Writes to such addresses, and to 0x8B, change nothing that can be read.
- R9: `dn_valid` stays high until `dn_ready` is seen high at a clock edge, and it is low in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe; read data is returned in the same cycle |
| host_rdata | output | 8 | Read data; 0 when `host_rd` is low |
| dn_valid | output | 1 | A request is presented downstream |
| dn_ready | input | 1 | Downstream engine accepts the request |
| dn_code | output | 16 | Attribute code of the request |
| dn_value | output | 16 | Attribute value of the request |

## Verification
The hardest case to reach is an issue write, followed by rewrites of all four staging bytes, arriving while a request is still held by back-pressure. The bench reaches it by setting the behavioural responder to a long acceptance delay. It then restages and re-issues while polling the busy bit, and the scoreboard proves that the one transfer that arrives carries the original code and value and that no second transfer follows. Zero-delay acceptance is also run, so the fall of `dn_valid` in the cycle after the transfer edge is covered.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } req_state_t;
endpackage

// File: rtl/attr_stage_regs.sv
module attr_stage_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ATTR_W = 16,
  parameter int BASE   = 'h84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ATTR_W-1:0] word,
  output logic              hit,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int NB = ATTR_W / DATA_W;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + gi);
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          byte_q <= '0;
      else if (wr_en && addr == MY_ADDR)   byte_q <= wdata;
    end
    assign word[gi*DATA_W +: DATA_W] = byte_q;
  end

  always_comb begin
    hit     = 1'b0;
    rd_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(BASE + i)) begin
        hit     = 1'b1;
        rd_byte = word[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/attr_req_ctrl.sv
module attr_req_ctrl
  import attr_pkg::*;
#(
  parameter int ATTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_req,
  input  logic              done_clr,
  input  logic [ATTR_W-1:0] stage_code,
  input  logic [ATTR_W-1:0] stage_value,
  input  logic              dn_ready,
  output logic              dn_valid,
  output logic [ATTR_W-1:0] dn_code,
  output logic [ATTR_W-1:0] dn_value,
  output logic              busy,
  output logic              done
);
  req_state_t state_q;
  logic       xfer;

  assign busy     = (state_q == ST_REQ);
  assign dn_valid = busy;
  assign xfer     = busy && dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dn_code  <= '0;
      dn_value <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (issue_req) begin
          state_q  <= ST_REQ;
          dn_code  <= stage_code;
          dn_value <= stage_value;
        end
        ST_REQ: if (dn_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // sticky completion flag: set has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (xfer)     done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end
endmodule

// File: rtl/attr_rd_mux.sv
module attr_rd_mux #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int DONE_ADDR = 'h8A,
  parameter int BUSY_ADDR = 'h8B,
  parameter int DONE_BIT  = 7,
  parameter int BUSY_BIT  = 0
) (
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              val_hit,
  input  logic [DATA_W-1:0] val_byte,
  input  logic              code_hit,
  input  logic [DATA_W-1:0] code_byte,
  input  logic              busy,
  input  logic              done,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (host_rd) begin
      if (val_hit)                              rdata = val_byte;
      else if (code_hit)                        rdata = code_byte;
      else if (addr == ADDR_W'(DONE_ADDR))      rdata[DONE_BIT] = done;
      else if (addr == ADDR_W'(BUSY_ADDR))      rdata[BUSY_BIT] = busy;
    end
  end
endmodule

// File: rtl/attr_req_bridge.sv
module attr_req_bridge #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int ATTR_W     = 16,
  parameter int VALUE_BASE = 'h84,
  parameter int CODE_BASE  = 'h86,
  parameter int DONE_ADDR  = 'h8A,
  parameter int BUSY_ADDR  = 'h8B,
  parameter int ISSUE_ADDR = 'h90,
  parameter int DONE_BIT   = 7,
  parameter int BUSY_BIT   = 0,
  parameter int ISSUE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ATTR_W-1:0] dn_code,
  output logic [ATTR_W-1:0] dn_value
);
  logic [ATTR_W-1:0] stage_value, stage_code;
  logic              val_hit, code_hit;
  logic [DATA_W-1:0] val_byte, code_byte;
  logic              busy, done;
  logic              issue_req, done_clr;

  assign issue_req = host_wr && host_addr == ADDR_W'(ISSUE_ADDR) && host_wdata[ISSUE_BIT];
  assign done_clr  = host_wr && host_addr == ADDR_W'(DONE_ADDR)  && host_wdata[DONE_BIT];

  attr_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .BASE(VALUE_BASE)) u_value (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr), .wdata(host_wdata),
    .word(stage_value), .hit(val_hit), .rd_byte(val_byte)
  );

  attr_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .BASE(CODE_BASE)) u_code (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr), .wdata(host_wdata),
    .word(stage_code), .hit(code_hit), .rd_byte(code_byte)
  );

  attr_req_ctrl #(.ATTR_W(ATTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .done_clr(done_clr),
    .stage_code(stage_code), .stage_value(stage_value), .dn_ready(dn_ready),
    .dn_valid(dn_valid), .dn_code(dn_code), .dn_value(dn_value),
    .busy(busy), .done(done)
  );

  attr_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DONE_ADDR(DONE_ADDR), .BUSY_ADDR(BUSY_ADDR),
                .DONE_BIT(DONE_BIT), .BUSY_BIT(BUSY_BIT)) u_rd (
    .host_rd(host_rd), .addr(host_addr), .val_hit(val_hit), .val_byte(val_byte),
    .code_hit(code_hit), .code_byte(code_byte), .busy(busy), .done(done), .rdata(host_rdata)
  );
endmodule

// File: rtl/attr_req_bridge_chk.sv
module attr_req_bridge_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int ATTR_W     = 16,
  parameter int VALUE_BASE = 'h84,
  parameter int CODE_BASE  = 'h86,
  parameter int DONE_ADDR  = 'h8A,
  parameter int BUSY_ADDR  = 'h8B,
  parameter int ISSUE_ADDR = 'h90,
  parameter int DONE_BIT   = 7,
  parameter int ISSUE_BIT  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [ATTR_W-1:0] dn_code,
  input logic [ATTR_W-1:0] dn_value,
  input logic              busy,
  input logic              done,
  input logic [ATTR_W-1:0] stage_code,
  input logic [ATTR_W-1:0] stage_value
);
  logic issue_w, clr_w, known_addr;
  assign issue_w = host_wr && host_addr == ADDR_W'(ISSUE_ADDR) && host_wdata[ISSUE_BIT];
  assign clr_w   = host_wr && host_addr == ADDR_W'(DONE_ADDR)  && host_wdata[DONE_BIT];
  assign known_addr = (host_addr >= ADDR_W'(VALUE_BASE) && host_addr < ADDR_W'(CODE_BASE + ATTR_W/DATA_W))
                   || host_addr == ADDR_W'(DONE_ADDR) || host_addr == ADDR_W'(BUSY_ADDR);

  assert_stage_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == ADDR_W'(VALUE_BASE) |=> stage_value[DATA_W-1:0] == $past(host_wdata));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && issue_w |=> dn_valid && dn_code == $past(stage_code) && dn_value == $past(stage_value));

  assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready |=> !busy && done);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && clr_w && !(dn_valid && dn_ready) |=> !done);

  assert_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> $stable(dn_code) && $stable(dn_value));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dn_ready && issue_w |=> busy && $stable(dn_code) && $stable(dn_value));

  assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !known_addr |-> host_rdata == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid);
endmodule

bind attr_req_bridge attr_req_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .VALUE_BASE(VALUE_BASE),
  .CODE_BASE(CODE_BASE), .DONE_ADDR(DONE_ADDR), .BUSY_ADDR(BUSY_ADDR),
  .ISSUE_ADDR(ISSUE_ADDR), .DONE_BIT(DONE_BIT), .ISSUE_BIT(ISSUE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_code(dn_code), .dn_value(dn_value),
  .busy(busy), .done(done), .stage_code(stage_code), .stage_value(stage_value)
);

// File: tb/tb_attr_req_bridge.sv
`timescale 1ns/1ps
module tb_attr_req_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [15:0] dn_code, dn_value;

  int checks = 0;
  int errors = 0;
  int ack_delay = 0;
  int hs_count = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  attr_req_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_code(dn_code), .dn_value(dn_value)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic stage(input logic [15:0] code, input logic [15:0] value);
    bus_wr(8'h84, value[7:0]);
    bus_wr(8'h85, value[15:8]);
    bus_wr(8'h86, code[7:0]);
    bus_wr(8'h87, code[15:8]);
  endtask

  // driver: expected transfer goes to the scoreboard, then the issue write
  task automatic issue(input logic [15:0] code, input logic [15:0] value);
    exp_q.push_back({code, value});
    bus_wr(8'h90, 8'h80);
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 500; i++) begin
      bus_rd(8'h8B, d);
      if (d[0] == 1'b0) break;
    end
    check("R4 busy returns to 0", d, 8'h00);
  endtask

  // responder + monitor: accepts after ack_delay cycles, pops and compares
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (dn_ready) begin
        dn_ready = 1'b0;
        check("R9 valid drops after transfer", dn_valid, 0);
      end else if (dn_valid && rst_n) begin
        if (wait_cnt >= ack_delay) begin
          logic [31:0] exp;
          wait_cnt = 0;
          hs_count++;
          if (exp_q.size() == 0) begin
            check("R7 unexpected transfer", 1, 0);
          end else begin
            exp = exp_q.pop_front();
            check("R6 transfer code", dn_code, exp[31:16]);
            check("R6 transfer value", dn_value, exp[15:0]);
          end
          dn_ready = 1'b1;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hs0;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_check("R1 reset value lo", 8'h84, 8'h00);
    rd_check("R1 reset value hi", 8'h85, 8'h00);
    rd_check("R2 reset code lo", 8'h86, 8'h00);
    rd_check("R2 reset code hi", 8'h87, 8'h00);
    rd_check("R5 reset done", 8'h8A, 8'h00);
    rd_check("R4 reset busy", 8'h8B, 8'h00);
    check("R9 reset valid", dn_valid, 0);

    // staging readback, pattern-checker control request
    stage(16'h0002, 16'h0125);
    rd_check("R1 value lo", 8'h84, 8'h25);
    rd_check("R1 value hi", 8'h85, 8'h01);
    rd_check("R2 code lo", 8'h86, 8'h02);
    rd_check("R2 code hi", 8'h87, 8'h00);

    // issue with bit 7 clear does nothing
    bus_wr(8'h90, 8'h7F);
    check("R3 no start without bit 7", dn_valid, 0);
    rd_check("R3 busy stays 0", 8'h8B, 8'h00);

    // zero-delay acceptance
    ack_delay = 0;
    hs0 = hs_count;
    issue(16'h0002, 16'h0125);
    check("R3 valid next cycle", dn_valid, 1);
    check("R3 code on port", dn_code, 16'h0002);
    wait_idle();
    check("R3 one transfer", hs_count - hs0, 1);
    rd_check("R3 issue reads 0", 8'h90, 8'h00);
    rd_check("R5 done set", 8'h8A, 8'h80);
    bus_wr(8'h8A, 8'h7F);
    rd_check("R5 write 0 keeps done", 8'h8A, 8'h80);
    bus_wr(8'h8A, 8'h80);
    rd_check("R5 write 1 clears done", 8'h8A, 8'h00);

    // long back-pressure: restage and re-issue in flight
    ack_delay = 12;
    hs0 = hs_count;
    stage(16'h1234, 16'hBEEF);
    issue(16'h1234, 16'hBEEF);
    rd_check("R4 busy while outstanding", 8'h8B, 8'h01);
    rd_check("R5 done clear while outstanding", 8'h8A, 8'h00);
    stage(16'hA5A5, 16'h5A5A);
    bus_wr(8'h90, 8'h80);
    check("R6 code held in flight", dn_code, 16'h1234);
    check("R6 value held in flight", dn_value, 16'hBEEF);
    wait_idle();
    repeat (30) @(negedge clk);
    check("R7 second issue ignored", hs_count - hs0, 1);
    check("R7 no pending request", dn_valid, 0);
    check("R7 scoreboard empty", exp_q.size(), 0);
    rd_check("R2 restaged code lo", 8'h86, 8'hA5);
    rd_check("R1 restaged value hi", 8'h85, 8'h5A);
    rd_check("R5 done after second request", 8'h8A, 8'h80);

    // short delay with restaged values
    ack_delay = 3;
    issue(16'hA5A5, 16'h5A5A);
    wait_idle();
    check("R3 scoreboard drained", exp_q.size(), 0);

    // unimplemented addresses
    bus_wr(8'h88, 8'hFF);
    rd_check("R8 unimplemented reads 0", 8'h88, 8'h00);
    bus_wr(8'h8B, 8'hFF);
    rd_check("R8 busy reg not writable", 8'h8B, 8'h00);
    rd_check("R8 addr 0x00 reads 0", 8'h00, 8'h00);
    rd_check("R8 addr 0xFF reads 0", 8'hFF, 8'h00);
    bus_rd(8'h84, d);
    check("R8 stray write kept value", d, 8'h5A);
    check("R8 no request from stray write", dn_valid, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule